// File: doc/BRIEF.md
# Infrared Serial Pulse-to-NRZ Receive Decoder

This block sits between an infrared receiver pin and a UART receiver. On the infrared link a logic 0 is sent as a short pulse inside its bit period, and a logic 1 is sent as no pulse at all. The decoder turns that pulse stream back into a plain NRZ bit stream. It also gives a one-cycle strobe for each recovered bit, so the UART can take bits without oversampling the line again.

The raw pin first passes through a synchroniser. The polarity select then maps it to an "active" level. A glitch filter follows: a small counter on the system clock that lets a pulse through only after it has stayed active long enough. The decoder keeps a bit window. The window counter advances on a 16x bit-rate sample enable, and the window is re-centred whenever an accepted pulse starts a frame. Each window ends with a strobe that carries 0 if an accepted pulse fell inside the window, and 1 if none did. After a set number of windows the decoder goes idle again and waits for the next start pulse.

Top module: `irda_sir_rx`

## Requirements
- R1: A synchronous reset forces `nrz_out` to 1 and `bit_valid` to 0 and clears all counters, with the decoder idle.
- R2: With `pol_sel` = 0 the pin idles low and a high level is the active pulse state.
- R3: With `pol_sel` = 1 the pin idles high and a low level is the active pulse state.
- R4: A pulse is accepted only when the synchronised pin has stayed active for 15 consecutive clock cycles (2^FILT_W - 1). A run of 14 cycles has no effect on the output. Each pulse is accepted at most once.
- R5: When idle, an accepted pulse is a start bit. It loads the window counter with phase 8 of 16, so the first strobe comes on the 8th sample enable after acceptance and carries 0.
- R6: Within a frame, consecutive strobes are exactly 16 sample enables apart, and a strobe only follows a cycle with `sample_en` high.
- R7: A window that contains an accepted pulse (the end cycle included) yields `nrz_out` = 0. A window without one yields 1. Filtered-out glitches inside a window do not turn a 1 into a 0.
- R8: `bit_valid` is high for exactly one clock per window. `nrz_out` changes only in the cycle where `bit_valid` is high.
- R9: After FRAME_BITS windows the decoder returns to idle and issues no strobe. The next accepted pulse starts a new frame with fresh centring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | One-cycle enable at 16x the bit rate |
| ir_in | input | 1 | Raw infrared receive pin (asynchronous) |
| pol_sel | input | 1 | 0: active-high pulses, 1: active-low pulses |
| nrz_out | output | 1 | Recovered NRZ bit, idles at 1 |
| bit_valid | output | 1 | One-cycle strobe marking a new recovered bit |

## Verification
The hardest situation to reach is the threshold of the glitch filter. A run of exactly 14 active cycles must be rejected and a run of 15 accepted, and the pin is only visible after two synchroniser stages. The bench drives pin pulses whose length is counted in clocks rather than sample ticks: a 14-clock and a 15-clock start pulse, and 14-clock glitches placed inside 1-bits. It then checks the strobes for a frame that never starts and for one that starts. Each frame's start offset is also moved against the sample-enable phase, so the re-centring is exercised at every phase.

// File: rtl/irdec_pkg.sv
package irdec_pkg;

  // pin level mapped to pulse-active: invert when the link is active-low
  function automatic logic active_of(input logic pin, input logic pol);
    return pin ^ pol;
  endfunction

  // saturating increment while active, clear when inactive
  function automatic int unsigned run_next(input int unsigned cur,
                                           input logic act,
                                           input int unsigned top);
    if (!act)       return 0;
    if (cur >= top) return top;
    return cur + 1;
  endfunction

  // bit value delivered for a window
  function automatic logic bit_of(input logic pulse_seen);
    return ~pulse_seen;
  endfunction

endpackage

// File: rtl/irdec_sync.sv
module irdec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_lvl,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q[0] <= rst_lvl;
          else     q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q[g] <= rst_lvl;
          else     q[g] <= q[g-1];
        end
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/irdec_glitch.sv
module irdec_glitch #(
  parameter int FILT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic pulse_det
);
  import irdec_pkg::*;

  localparam int unsigned FILT_TOP = (1 << FILT_W) - 1;

  logic [FILT_W-1:0] run_q;

  // accepted on the cycle the counter would reach its top value
  assign pulse_det = active && (run_q == FILT_W'(FILT_TOP - 1));

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= FILT_W'(run_next(int'(run_q), active, FILT_TOP));
  end
endmodule

// File: rtl/irdec_window.sv
module irdec_window #(
  parameter int PH_W       = 4,
  parameter int FRAME_BITS = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            pulse_det,
  output logic            start_evt,
  output logic            busy,
  output logic [PH_W-1:0] win_ph,
  output logic            nrz_out,
  output logic            bit_valid
);
  import irdec_pkg::*;

  localparam int BC_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [PH_W-1:0] PH_CENTRE = PH_W'(1 << (PH_W - 1));
  localparam logic [PH_W-1:0] PH_LAST   = {PH_W{1'b1}};
  localparam logic [BC_W-1:0] BC_LAST   = BC_W'(FRAME_BITS - 1);

  logic            busy_q;
  logic [PH_W-1:0] ph_q;
  logic            seen_q;
  logic [BC_W-1:0] bc_q;
  logic            nrz_q;
  logic            vld_q;
  logic            win_end;

  assign start_evt = !busy_q && pulse_det;
  assign win_end   = busy_q && tick && (ph_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      seen_q <= 1'b0;
      bc_q   <= '0;
      nrz_q  <= 1'b1;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (start_evt) begin
        busy_q <= 1'b1;
        ph_q   <= PH_CENTRE;
        seen_q <= 1'b1;
        bc_q   <= '0;
      end else if (busy_q) begin
        if (pulse_det) seen_q <= 1'b1;
        if (tick) ph_q <= ph_q + 1'b1;
        if (win_end) begin
          vld_q  <= 1'b1;
          nrz_q  <= bit_of(seen_q | pulse_det);
          seen_q <= 1'b0;
          if (bc_q == BC_LAST) begin
            busy_q <= 1'b0;
            bc_q   <= '0;
          end else begin
            bc_q <= bc_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign win_ph    = ph_q;
  assign nrz_out   = nrz_q;
  assign bit_valid = vld_q;
endmodule

// File: rtl/irda_sir_rx.sv
module irda_sir_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 4,
  parameter int PH_W        = 4,
  parameter int FRAME_BITS  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic ir_in,
  input  logic pol_sel,
  output logic nrz_out,
  output logic bit_valid
);
  import irdec_pkg::*;

  logic            pin_s;
  logic            active;
  logic            pulse_det;
  logic            start_evt;
  logic            busy;
  logic [PH_W-1:0] win_ph;

  irdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .rst_lvl(pol_sel),
    .din    (ir_in),
    .dout   (pin_s)
  );

  assign active = active_of(pin_s, pol_sel);

  irdec_glitch #(.FILT_W(FILT_W)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .pulse_det(pulse_det)
  );

  irdec_window #(.PH_W(PH_W), .FRAME_BITS(FRAME_BITS)) u_win (
    .clk      (clk),
    .rst      (rst),
    .tick     (sample_en),
    .pulse_det(pulse_det),
    .start_evt(start_evt),
    .busy     (busy),
    .win_ph   (win_ph),
    .nrz_out  (nrz_out),
    .bit_valid(bit_valid)
  );
endmodule

// File: rtl/irdec_checker.sv
module irdec_checker #(
  parameter int FILT_W = 4,
  parameter int PH_W   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            sample_en,
  input logic            active,
  input logic            pulse_det,
  input logic            start_evt,
  input logic            busy,
  input logic [PH_W-1:0] win_ph,
  input logic            nrz_out,
  input logic            bit_valid
);
  localparam int unsigned RUN_GOAL = (1 << FILT_W) - 2;

  // independent count of active cycles preceding the current one
  logic [7:0] run_c;
  always_ff @(posedge clk) begin
    if (rst)              run_c <= '0;
    else if (!active)     run_c <= '0;
    else if (run_c != '1) run_c <= run_c + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (nrz_out && !bit_valid));

  assert_filter_span_R4: assert property (@(posedge clk) disable iff (rst)
    pulse_det |-> (active && run_c == 8'(RUN_GOAL)));

  assert_single_accept_R4: assert property (@(posedge clk) disable iff (rst)
    pulse_det |=> !pulse_det);

  assert_start_centre_R5: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (busy && win_ph == PH_W'(1 << (PH_W - 1))));

  assert_strobe_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(sample_en));

  assert_one_cycle_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> $stable(nrz_out));

  assert_no_idle_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(busy));
endmodule

bind irda_sir_rx irdec_checker #(.FILT_W(FILT_W), .PH_W(PH_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sample_en(sample_en),
  .active   (active),
  .pulse_det(pulse_det),
  .start_evt(start_evt),
  .busy     (busy),
  .win_ph   (win_ph),
  .nrz_out  (nrz_out),
  .bit_valid(bit_valid)
);

// File: tb/sim_irda_sir_rx.sv
`timescale 1ns/1ps
module sim_irda_sir_rx;
  localparam int T     = 6;       // clocks per sample enable
  localparam int SLOT  = 16 * T;  // clocks per bit
  localparam int NBITS = 6;       // start + 4 data + stop

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0;
  logic ir_in = 1'b0;
  logic pol_sel = 1'b0;
  logic nrz_out, bit_valid;

  int cyc = 0;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  int n_rx = 0;
  int rx_cyc [64];
  bit rx_bit [64];
  int rise_cyc = 0;

  always #2.5 clk = ~clk;

  irda_sir_rx #(.FRAME_BITS(NBITS)) u0 (
    .clk(clk), .rst(rst), .sample_en(sample_en), .ir_in(ir_in),
    .pol_sel(pol_sel), .nrz_out(nrz_out), .bit_valid(bit_valid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk);
    sample_en <= ((cyc % T) == T - 1);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: collect strobes, check R8 strobe width and hold
  logic prev_v = 1'b0;
  logic prev_n = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (bit_valid) begin
        if (n_rx < 64) begin
          rx_cyc[n_rx] = cyc;
          rx_bit[n_rx] = nrz_out;
        end
        n_rx++;
        if (prev_v) chk(1'b0, "R8 strobe longer than one cycle", 1, 0);
      end else if (nrz_out !== prev_n) begin
        chk(1'b0, "R8 nrz changed without strobe", int'(nrz_out), int'(prev_n));
      end
    end
    prev_v = bit_valid;
    prev_n = nrz_out;
  end

  // one frame: start pulse of sw clocks, 0-bits pulse 3T clocks,
  // glitch[i] puts a 14-clock spike into data bit i when it is a 1
  task automatic send_frame(input bit pol, input logic [3:0] data,
                            input int sw, input logic [3:0] glitch);
    for (int s = 0; s < NBITS; s++) begin
      int w;
      if (s == 0)              w = sw;
      else if (s == NBITS - 1) w = 0;
      else if (!data[s-1])     w = 3 * T;
      else if (glitch[s-1])    w = 14;
      else                     w = 0;
      for (int k = 0; k < SLOT; k++) begin
        @(negedge clk);
        if (s == 0 && k == 0) rise_cyc = cyc;
        ir_in <= pol ^ (k < w);
      end
    end
  endtask

  task automatic run_frame(input bit pol, input logic [3:0] data, input int sw,
                           input logic [3:0] glitch, input int jitter,
                           input string preq);
    bit accept;
    n_rx = 0;
    send_frame(pol, data, sw, glitch);
    repeat (2 * SLOT + jitter) @(negedge clk);
    accept = (sw >= 15);
    if (!accept) begin
      chk(n_rx == 0, "R4 short start pulse rejected, strobes", n_rx, 0);
      chk(nrz_out == 1'b1, "R4 line stays idle", int'(nrz_out), 1);
      return;
    end
    chk(n_rx == NBITS, "R9 strobes per frame", n_rx, NBITS);
    if (n_rx != NBITS) return;
    begin
      int lat;
      lat = rx_cyc[0] - rise_cyc;
      chk(lat >= 7 * T + 10 && lat <= 8 * T + 22, "R5 first strobe latency", lat, 8 * T + 17);
    end
    chk(rx_bit[0] == 1'b0, "R5 start bit recovered as 0", int'(rx_bit[0]), 0);
    for (int i = 1; i < NBITS; i++) begin
      logic exp_b;
      exp_b = (i == NBITS - 1) ? 1'b1 : data[i-1];
      chk(rx_bit[i] == exp_b, $sformatf("R7 %s bit %0d", preq, i), int'(rx_bit[i]), int'(exp_b));
      chk(rx_cyc[i] - rx_cyc[i-1] == SLOT, "R6 strobe spacing", rx_cyc[i] - rx_cyc[i-1], SLOT);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(nrz_out == 1'b1, "R1 reset nrz_out", int'(nrz_out), 1);
    chk(bit_valid == 1'b0, "R1 reset bit_valid", int'(bit_valid), 0);
    @(negedge clk);
    rst <= 1'b0;
    repeat (3 * SLOT) @(negedge clk);
    chk(n_rx == 0, "R9 no strobe while idle", n_rx, 0);

    // exhaustive data sweep in both polarities (R2, R3)
    for (int p = 0; p < 2; p++) begin
      pol_sel <= p[0];
      ir_in   <= p[0];
      repeat (2 * SLOT) @(negedge clk);
      for (int d = 0; d < 16; d++)
        run_frame(p[0], d[3:0], 3 * T, 4'h0, (d * 5) % 23, p ? "R3 pol1" : "R2 pol0");
    end

    // glitch filter threshold (R4) in both polarities
    for (int p = 0; p < 2; p++) begin
      pol_sel <= p[0];
      ir_in   <= p[0];
      repeat (2 * SLOT) @(negedge clk);
      run_frame(p[0], 4'hF, 14, 4'h0, 3, "R4 sw14");
      run_frame(p[0], 4'hF, 15, 4'h0, 7, "R4 sw15");
      run_frame(p[0], 4'hF, 3 * T, 4'hF, 1, "R7 glitch in ones");
      run_frame(p[0], 4'h5, 3 * T, 4'hA, 11, "R7 glitch mixed");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule